// File: doc/BRIEF.md
# Reset-Cause and Supply-Warning Status Register

This block is one byte-wide control/status register of a microcontroller's system-integrity unit. It records which kind of reset most recently hit the chip. The choices are the external reset pin, a watchdog timeout, or a low-voltage reset. It also shows whether the PLL has locked and whether the supply is currently below a warning threshold, and it raises an interrupt when that warning appears. The register also holds two software-owned oscillator trim bits and the warning-interrupt enable.

The reset-cause flags do not all persist the same way. The low-voltage flag survives external and watchdog resets, so the original fault is still visible afterwards. A low-voltage reset wipes the watchdog flag. Both cause flags clear when software reads the register. The lock flag is cleared only by power-on reset. Software decodes the cause as follows:
- both flags at 0 means an external pin reset;
- only the watchdog flag at 1 means a watchdog reset;
- the low-voltage flag at 1 means a low-voltage reset, whatever the watchdog flag holds.

Top module: `shr_status_reg`

Bit map (MSB to LSB):
- bit 7: reserved, reads 0
- bits 6:5: oscillator trim
- bit 4: watchdog-reset flag
- bit 3: PLL-lock flag
- bit 2: low-voltage-reset flag
- bit 1: supply-warning flag
- bit 0: warning-interrupt enable

## Requirements
- R1: After power-on reset (`por_n_i` low, asynchronous), with the supply above threshold, `bus_rdata_o` reads 8'h60 and `irq_o` is 0. Bit 7 always reads 0.
- R2: A write strobe loads bits 6:5 and bit 0 from `bus_wdata_i` on the next clock edge. Bits 7, 4, 3, 2 and 1 are unaffected by writes.
- R3: Any warm reset event (external, watchdog or low-voltage) reloads trim to 2'b11, clears the enable and clears a pending interrupt on the next edge. It wins over a write in the same cycle.
- R4: A watchdog reset event sets bit 4 on the next edge. A low-voltage reset event sets bit 2 and clears bit 4, even when both events arrive in the same cycle.
- R5: During a read strobe, `bus_rdata_o` shows the value before clearing. On the next edge, bits 4 and 2 clear, unless a set event for that bit arrives in the same cycle, in which case the set wins.
- R6: External and watchdog reset events leave bit 2 unchanged. An external reset event leaves bit 4 unchanged.
- R7: Bit 3 is set on the edge after `pll_lock_i` is high. Reads, writes and warm resets leave it unchanged; only power-on reset clears it.
- R8: While `lvd_disable_i` is high, bit 2 is forced to 0 from the next edge on, and low-voltage events do not set it.
- R9: Bit 1 equals `supply_low_i` as sampled SYNC_STAGES clock edges earlier, through a synchronizer chain reset to 0.
- R10: `irq_o` rises on the edge where bit 1 goes from 0 to 1, if bit 0 is 1 before that edge. It then holds until the edge after `irq_ack_i`. A new rise in the acknowledge cycle wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset, asynchronous, active low |
| bus_rd_i | input | 1 | Read strobe (triggers flag clearing) |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Current register value |
| rst_ext_evt_i | input | 1 | External-pin reset occurred (one-cycle pulse) |
| rst_wdg_evt_i | input | 1 | Watchdog reset occurred (one-cycle pulse) |
| rst_lvd_evt_i | input | 1 | Low-voltage reset occurred (one-cycle pulse) |
| lvd_disable_i | input | 1 | Low-voltage detector disabled by configuration |
| pll_lock_i | input | 1 | PLL reached its operating frequency |
| supply_low_i | input | 1 | Supply comparator level, 1 when below the warning threshold |
| irq_o | output | 1 | Supply-warning interrupt request |
| irq_ack_i | input | 1 | Interrupt handler entered |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This moves the warning flag and the interrupt three edges behind the comparator input, so a mistake in the chain length or an extra register stage shows up as an off-by-one cycle. TRIM_RST keeps its default of 2'b11, so the reset value 8'h60 and the warm-reset reload are checked directly. A behavioural model, built on a queue of the comparator history, is compared against the read data and the interrupt on every cycle. Colliding events are driven deliberately: read with set, low-voltage with watchdog, and write with warm reset.

// File: rtl/shr_pkg.sv
package shr_pkg;
    localparam int REG_W       = 8;
    localparam int BIT_RSV     = 7;
    localparam int BIT_TRIM_HI = 6;
    localparam int BIT_TRIM_LO = 5;
    localparam int BIT_WDG     = 4;
    localparam int BIT_LOCK    = 3;
    localparam int BIT_LVD     = 2;
    localparam int BIT_AVD     = 1;
    localparam int BIT_IE      = 0;
    localparam int TRIM_W      = BIT_TRIM_HI - BIT_TRIM_LO + 1;

    // software-writable bit positions
    localparam logic [REG_W-1:0] WR_MASK =
        REG_W'((((1 << TRIM_W) - 1) << BIT_TRIM_LO) | (1 << BIT_IE));

    typedef struct packed {
        logic wdg;
        logic lock;
        logic lvd;
    } cause_t;
endpackage

// File: rtl/shr_cause_flags.sv
module shr_cause_flags
    import shr_pkg::*;
(
    input  logic   clk_i,
    input  logic   por_n_i,
    input  logic   rd_i,
    input  logic   wdg_evt_i,
    input  logic   lvd_evt_i,
    input  logic   lvd_off_i,
    input  logic   pll_lock_i,
    output cause_t flags_o
);
    cause_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        // watchdog flag: low-voltage reset wins, then set, then read-clear
        if (lvd_evt_i)
            flags_d.wdg = 1'b0;
        else if (wdg_evt_i)
            flags_d.wdg = 1'b1;
        else if (rd_i)
            flags_d.wdg = 1'b0;
        // low-voltage flag: forced low when detector disabled
        if (lvd_off_i)
            flags_d.lvd = 1'b0;
        else if (lvd_evt_i)
            flags_d.lvd = 1'b1;
        else if (rd_i)
            flags_d.lvd = 1'b0;
        // lock flag: sticky until power-on
        if (pll_lock_i)
            flags_d.lock = 1'b1;
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    assert_wdg_set_R4: assert property (@(posedge clk_i) disable iff (!por_n_i)
        wdg_evt_i && !lvd_evt_i |=> flags_q.wdg);
    assert_lvd_clears_wdg_R4: assert property (@(posedge clk_i) disable iff (!por_n_i)
        lvd_evt_i |=> !flags_q.wdg);
    assert_read_clears_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
        rd_i && !wdg_evt_i && !lvd_evt_i |=> !flags_q.wdg && !flags_q.lvd);
    assert_lvd_survives_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
        flags_q.lvd && !rd_i && !lvd_off_i |=> flags_q.lvd);
    assert_lock_sticky_R7: assert property (@(posedge clk_i) disable iff (!por_n_i)
        flags_q.lock |=> flags_q.lock);
    assert_lvd_forced_R8: assert property (@(posedge clk_i) disable iff (!por_n_i)
        lvd_off_i |=> !flags_q.lvd);
endmodule

// File: rtl/shr_ctrl_field.sv
module shr_ctrl_field
    import shr_pkg::*;
#(
    parameter logic [TRIM_W-1:0] TRIM_RST = '1
) (
    input  logic             clk_i,
    input  logic             por_n_i,
    input  logic             warm_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] ctrl_o
);
    localparam logic [REG_W-1:0] CTRL_RST = REG_W'(TRIM_RST) << BIT_TRIM_LO;

    logic [REG_W-1:0] ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (warm_i)
            ctrl_d = CTRL_RST;
        else if (wr_i)
            ctrl_d = wdata_i & WR_MASK;
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i)
            ctrl_q <= CTRL_RST;
        else
            ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;

    assert_warm_reload_R3: assert property (@(posedge clk_i) disable iff (!por_n_i)
        warm_i |=> ctrl_q[BIT_TRIM_HI:BIT_TRIM_LO] == TRIM_RST && !ctrl_q[BIT_IE]);
    assert_write_trim_R2: assert property (@(posedge clk_i) disable iff (!por_n_i)
        wr_i && !warm_i |=> ctrl_q[BIT_TRIM_HI:BIT_TRIM_LO] == $past(wdata_i[BIT_TRIM_HI:BIT_TRIM_LO]));
endmodule

// File: rtl/shr_supply_mon.sv
module shr_supply_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic warm_i,
    input  logic supply_low_i,
    input  logic ie_i,
    input  logic ack_i,
    output logic avdf_o,
    output logic irq_o
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   pend;
    } mon_t;

    mon_t mon_d, mon_q;
    logic [SYNC_STAGES-1:0] chain_next;
    logic                   rise;

    generate
        if (SYNC_STAGES > 1) begin : g_multi
            assign chain_next = {mon_q.chain[SYNC_STAGES-2:0], supply_low_i};
        end else begin : g_single
            assign chain_next = supply_low_i;
        end
    endgenerate

    assign rise = chain_next[LAST] && !mon_q.chain[LAST];

    always_comb begin
        mon_d       = mon_q;
        mon_d.chain = chain_next;
        if (warm_i)
            mon_d.pend = 1'b0;
        else if (rise && ie_i)
            mon_d.pend = 1'b1;
        else if (ack_i)
            mon_d.pend = 1'b0;
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i)
            mon_q <= '0;
        else
            mon_q <= mon_d;
    end

    assign avdf_o = mon_q.chain[LAST];
    assign irq_o  = mon_q.pend;

    assert_irq_needs_enable_R10: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $rose(mon_q.pend) |-> $past(ie_i) && $rose(avdf_o));
    assert_ack_clears_R10: assert property (@(posedge clk_i) disable iff (!por_n_i)
        ack_i |=> !mon_q.pend || $rose(avdf_o));
    assert_warm_clears_irq_R3: assert property (@(posedge clk_i) disable iff (!por_n_i)
        warm_i |=> !irq_o);
endmodule

// File: rtl/shr_status_reg.sv
module shr_status_reg
    import shr_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [TRIM_W-1:0] TRIM_RST    = '1
) (
    input  logic             clk_i,
    input  logic             por_n_i,
    input  logic             bus_rd_i,
    input  logic             bus_wr_i,
    input  logic [REG_W-1:0] bus_wdata_i,
    output logic [REG_W-1:0] bus_rdata_o,
    input  logic             rst_ext_evt_i,
    input  logic             rst_wdg_evt_i,
    input  logic             rst_lvd_evt_i,
    input  logic             lvd_disable_i,
    input  logic             pll_lock_i,
    input  logic             supply_low_i,
    output logic             irq_o,
    input  logic             irq_ack_i
);
    logic             warm;
    cause_t           flags;
    logic [REG_W-1:0] ctrl;
    logic             avdf;
    logic [REG_W-1:0] status;

    assign warm = rst_ext_evt_i | rst_wdg_evt_i | rst_lvd_evt_i;

    shr_cause_flags u_flags (
        .clk_i      (clk_i),
        .por_n_i    (por_n_i),
        .rd_i       (bus_rd_i),
        .wdg_evt_i  (rst_wdg_evt_i),
        .lvd_evt_i  (rst_lvd_evt_i),
        .lvd_off_i  (lvd_disable_i),
        .pll_lock_i (pll_lock_i),
        .flags_o    (flags)
    );

    shr_ctrl_field #(.TRIM_RST(TRIM_RST)) u_ctrl (
        .clk_i   (clk_i),
        .por_n_i (por_n_i),
        .warm_i  (warm),
        .wr_i    (bus_wr_i),
        .wdata_i (bus_wdata_i),
        .ctrl_o  (ctrl)
    );

    shr_supply_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk_i        (clk_i),
        .por_n_i      (por_n_i),
        .warm_i       (warm),
        .supply_low_i (supply_low_i),
        .ie_i         (ctrl[BIT_IE]),
        .ack_i        (irq_ack_i),
        .avdf_o       (avdf),
        .irq_o        (irq_o)
    );

    always_comb begin
        status           = '0;
        status[BIT_WDG]  = flags.wdg;
        status[BIT_LOCK] = flags.lock;
        status[BIT_LVD]  = flags.lvd;
        status[BIT_AVD]  = avdf;
    end

    assign bus_rdata_o = status | ctrl;

    assert_reserved_zero_R1: assert property (@(posedge clk_i) disable iff (!por_n_i)
        bus_wr_i |=> !bus_rdata_o[BIT_RSV]);
    assert_write_no_status_R2: assert property (@(posedge clk_i) disable iff (!por_n_i)
        bus_wr_i && !pll_lock_i |=> bus_rdata_o[BIT_LOCK] == $past(bus_rdata_o[BIT_LOCK]));
endmodule

// File: tb/shr_status_reg_test.sv
module shr_status_reg_test;
    localparam int S = 3;

    logic       clk_i = 0;
    logic       por_n_i = 0;
    logic       bus_rd_i = 0, bus_wr_i = 0;
    logic [7:0] bus_wdata_i = 0;
    logic [7:0] bus_rdata_o;
    logic       rst_ext_evt_i = 0, rst_wdg_evt_i = 0, rst_lvd_evt_i = 0;
    logic       lvd_disable_i = 0, pll_lock_i = 0, supply_low_i = 0;
    logic       irq_o;
    logic       irq_ack_i = 0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] last_rd;

    always #2 clk_i = ~clk_i;

    shr_status_reg #(.SYNC_STAGES(S), .TRIM_RST(2'b11)) uut (.*);

    // behavioural reference
    int m_wdg, m_lvd, m_lock, m_trim, m_ie, m_pend;
    int hist[$];

    function automatic logic [7:0] model_val();
        return 8'((m_trim << 5) | (m_wdg << 4) | (m_lock << 3) | (m_lvd << 2) |
                  (hist[S-1] << 1) | m_ie);
    endfunction

    always @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            m_wdg = 0; m_lvd = 0; m_lock = 0; m_trim = 3; m_ie = 0; m_pend = 0;
            hist.delete();
            for (int i = 0; i < S; i++) hist.push_back(0);
        end else begin
            int old_avd, warm;
            old_avd = hist[S-1];
            hist.push_front(int'(supply_low_i));
            void'(hist.pop_back());
            warm = rst_ext_evt_i || rst_wdg_evt_i || rst_lvd_evt_i;
            if (warm) m_pend = 0;
            else if (hist[S-1] == 1 && old_avd == 0 && m_ie == 1) m_pend = 1;
            else if (irq_ack_i) m_pend = 0;
            if (rst_lvd_evt_i) m_wdg = 0;
            else if (rst_wdg_evt_i) m_wdg = 1;
            else if (bus_rd_i) m_wdg = 0;
            if (lvd_disable_i) m_lvd = 0;
            else if (rst_lvd_evt_i) m_lvd = 1;
            else if (bus_rd_i) m_lvd = 0;
            if (pll_lock_i) m_lock = 1;
            if (warm) begin m_trim = 3; m_ie = 0; end
            else if (bus_wr_i) begin m_trim = (bus_wdata_i >> 5) & 3; m_ie = bus_wdata_i[0]; end
        end
    end

    always @(negedge clk_i) begin
        if (por_n_i) begin
            checks++;
            if (bus_rdata_o !== model_val() || irq_o !== (m_pend != 0)) begin
                errors++;
                $display("FAIL per-cycle model (all requirements): rdata=%h irq=%b expected rdata=%h irq=%0d",
                         bus_rdata_o, irq_o, model_val(), m_pend);
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic rd, input logic wr, input logic [7:0] wd,
                       input logic ext, input logic wdg, input logic lvd);
        @(negedge clk_i);
        bus_rd_i = rd; bus_wr_i = wr; bus_wdata_i = wd;
        rst_ext_evt_i = ext; rst_wdg_evt_i = wdg; rst_lvd_evt_i = lvd;
        #1 last_rd = bus_rdata_o;
        @(negedge clk_i);
        bus_rd_i = 0; bus_wr_i = 0; bus_wdata_i = 0;
        rst_ext_evt_i = 0; rst_wdg_evt_i = 0; rst_lvd_evt_i = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_i);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk_i);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
                finish_run();
            end
        end
    end

    initial begin
        idle(3);
        por_n_i = 1;
        idle(1);
        check("R1 reset value", bus_rdata_o, 8'h60);
        check("R1 irq idle", {7'd0, irq_o}, 8'h00);

        cyc(0, 1, 8'hFF, 0, 0, 0);
        check("R2 write all ones", bus_rdata_o, 8'h61);
        cyc(0, 1, 8'h00, 0, 0, 0);
        check("R2 write zeros", bus_rdata_o, 8'h00);
        cyc(0, 1, 8'h41, 0, 0, 0);
        check("R2 write trim 10 ie", bus_rdata_o, 8'h41);

        @(negedge clk_i) pll_lock_i = 1;
        @(negedge clk_i) pll_lock_i = 0;
        check("R7 lock set", bus_rdata_o, 8'h49);

        cyc(0, 0, 0, 0, 1, 0);
        check("R4 R3 watchdog event", bus_rdata_o, 8'h78);
        cyc(1, 0, 0, 0, 0, 0);
        check("R5 read returns pre-clear", last_rd, 8'h78);
        check("R5 R7 read clears flags not lock", bus_rdata_o, 8'h68);

        cyc(0, 0, 0, 0, 0, 1);
        check("R4 low-voltage event", bus_rdata_o, 8'h6C);
        cyc(0, 0, 0, 0, 1, 0);
        check("R6 watchdog keeps lvd flag", bus_rdata_o, 8'h7C);
        cyc(0, 1, 8'h00, 0, 0, 0);
        check("R2 write leaves flags", bus_rdata_o, 8'h1C);
        cyc(0, 1, 8'h01, 1, 0, 0);
        check("R3 R6 external reset wins over write", bus_rdata_o, 8'h7C);

        cyc(1, 0, 0, 0, 1, 0);
        check("R5 set wins over read-clear", bus_rdata_o, 8'h78);
        cyc(0, 0, 0, 0, 1, 1);
        check("R4 lvd and wdg together", bus_rdata_o, 8'h6C);

        @(negedge clk_i) lvd_disable_i = 1;
        @(negedge clk_i);
        check("R8 disable forces lvd 0", bus_rdata_o, 8'h68);
        cyc(0, 0, 0, 0, 0, 1);
        check("R8 lvd event ignored", bus_rdata_o, 8'h68);
        lvd_disable_i = 0;

        cyc(0, 1, 8'h61, 0, 0, 0);
        check("R2 enable interrupt", bus_rdata_o, 8'h69);
        supply_low_i = 1;
        idle(2);
        check("R9 warning not yet visible", bus_rdata_o & 8'h02, 8'h00);
        idle(1);
        check("R9 warning after chain", bus_rdata_o & 8'h02, 8'h02);
        check("R10 irq raised", {7'd0, irq_o}, 8'h01);
        cyc(0, 1, 8'h03, 0, 0, 0);
        check("R2 R9 bit1 not writable", bus_rdata_o, 8'h0B);
        check("R10 irq held", {7'd0, irq_o}, 8'h01);
        @(negedge clk_i) irq_ack_i = 1;
        @(negedge clk_i) irq_ack_i = 0;
        check("R10 ack clears", {7'd0, irq_o}, 8'h00);

        supply_low_i = 0;
        idle(S);
        check("R9 warning cleared", bus_rdata_o & 8'h02, 8'h00);
        cyc(0, 1, 8'h00, 0, 0, 0);
        supply_low_i = 1;
        idle(S + 1);
        check("R9 warning again", bus_rdata_o & 8'h02, 8'h02);
        check("R10 no irq when disabled", {7'd0, irq_o}, 8'h00);
        supply_low_i = 0;
        idle(S + 1);

        cyc(0, 1, 8'h01, 0, 0, 0);
        supply_low_i = 1;
        idle(S);
        check("R10 irq second rise", {7'd0, irq_o}, 8'h01);
        cyc(0, 0, 0, 1, 0, 0);
        check("R3 warm reset clears irq", {7'd0, irq_o}, 8'h00);
        supply_low_i = 0;
        idle(S + 1);

        @(negedge clk_i) por_n_i = 0;
        @(negedge clk_i) por_n_i = 1;
        check("R1 R7 power-on clears lock", bus_rdata_o, 8'h60);

        idle(2);
        finish_run();
    end
endmodule